// File: doc/BRIEF.md
# Serial Transmitter with Address/Data Marker Bit

This block serializes bytes onto a single asynchronous output line for a multidrop link in which every frame tells receivers whether it carries a station address or a payload byte. A writer places a byte in a holding register with a one-cycle strobe and supplies a marker value alongside it. The marker is 1 to tag the frame as an address and 0 to tag it as payload. The block moves the held byte into its shifter whenever the shifter is free and sends it out. It then reports through two flags, each with its own one-cycle request pulse. One flag says the holding register can take another byte. The other says the line has fallen idle.

Bit timing comes from an external tick enable. Each bit stays on the line for a fixed number of ticks, 16 by default. Baud-rate generation, parity and any bus interface lie outside the block. A writer that refills the holding register before the current stop bit finishes gets continuous back-to-back frames. If it does not refill in time, the line drops back to the idle mark level.

Top module: `mptx_serial_tx`

## Requirements
- R1: While rst_ni is low and right after its release, txd_o is 1, hold_empty_o is 1, line_idle_o is 1, and both request pulses are 0.
- R2: A frame is 11 bits: one start bit of 0, then data bits 0 to 7 with bit 0 first, then the marker bit, then one stop bit of 1.
- R3: The marker bit of a frame equals mpb_i as sampled in the same cycle as the write strobe of that frame's byte.
- R4: Each bit stays on txd_o for exactly 16 tick_i pulses. txd_o changes only on a cycle with tick_i high, or when a byte is moved into an idle shifter.
- R5: A write strobe clears hold_empty_o and line_idle_o to 0 in the next cycle.
- R6: Moving the held byte into the shifter sets hold_empty_o to 1 and gives one pulse on hold_req_o. This happens unless a write lands in the same cycle, in which case the write keeps the flag at 0. There is exactly one pulse per frame sent.
- R7: A write to an idle block shows the start bit on txd_o two cycles after the strobe cycle. The line is still 1 in the cycle after the strobe.
- R8: If a byte is held when a stop bit ends, the start bit of the next frame follows in the very next cycle, with no idle period.
- R9: If nothing is held when a stop bit ends, txd_o stays at 1, line_idle_o becomes 1, and idle_req_o pulses once. A write landing in that same cycle is too late for chaining: the line idles for one cycle with line_idle_o at 0 and no pulse, and then the frame starts. line_idle_o is 0 while a frame is being sent.
- R10: A second write while hold_empty_o is 0 replaces the held byte and marker. Only the newer byte is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Bit-time tick enable (16 per bit) |
| wr_i | input | 1 | Write strobe for the holding register |
| wdata_i | input | 8 | Byte to send |
| mpb_i | input | 1 | Marker bit for the byte: 1 address, 0 payload |
| txd_o | output | 1 | Serial line, idle level 1 |
| hold_empty_o | output | 1 | Holding register can accept a byte |
| line_idle_o | output | 1 | Last frame finished and nothing is held |
| hold_req_o | output | 1 | One-cycle request: holding register just emptied |
| idle_req_o | output | 1 | One-cycle request: line just went idle |

## Verification
Frames are sent under two tick patterns. With sparse, irregular ticks, the test shows that bit timing depends on counting ticks and not on clock cycles. With a tick on every cycle and immediate refills, the test exercises the back-to-back path, where a missing or extra gap cycle becomes visible. Writes are timed at random, so some land on an idle line, some during a frame, and some exactly on the closing stop-bit cycle. This separates the chained, idle and late-write outcomes. Directed sequences cover the two-cycle start latency and the overwrite of a byte that is still held.

// File: rtl/mptx_pkg.sv
package mptx_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned FRAME_W = DATA_W + 3;  // start, data, marker, stop
  localparam int unsigned TICKS   = 16;
endpackage

// File: rtl/mptx_bit_timer.sv
module mptx_bit_timer #(
  parameter int unsigned TICKS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  input  logic tick_i,
  output logic bit_end_o
);
  localparam int unsigned CW = (TICKS > 2) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (restart_i)          cnt_q <= '0;
    else if (run_i && tick_i)    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign bit_end_o = run_i && tick_i && (cnt_q == LAST);

  a_r4_count_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/mptx_shifter.sv
module mptx_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              mpb_i,
  input  logic              shift_i,
  output logic              txd_o,
  output logic              last_o
);
  localparam int unsigned FRAME_W = DATA_W + 3;
  localparam int unsigned IW      = $clog2(FRAME_W);

  logic [FRAME_W-1:0] sr_q;
  logic [IW-1:0]      idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '1;
      idx_q <= '0;
    end else if (load_i) begin
      sr_q  <= {1'b1, mpb_i, data_i, 1'b0};
      idx_q <= '0;
    end else if (shift_i) begin
      sr_q  <= {1'b1, sr_q[FRAME_W-1:1]};
      idx_q <= (idx_q == IW'(FRAME_W - 1)) ? '0 : idx_q + 1'b1;
    end
  end

  assign txd_o  = sr_q[0];
  assign last_o = (idx_q == IW'(FRAME_W - 1));

  a_r2_stop_is_mark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> txd_o);
endmodule

// File: rtl/mptx_serial_tx.sv
module mptx_serial_tx
  import mptx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              mpb_i,
  output logic              txd_o,
  output logic              hold_empty_o,
  output logic              line_idle_o,
  output logic              hold_req_o,
  output logic              idle_req_o
);
  logic [DATA_W-1:0] hold_q;
  logic              hold_mpb_q;
  logic              empty_q, idle_q, busy_q, hreq_q, ireq_q;
  logic              bit_end, last_bit, frame_end, load, shift;

  assign frame_end = bit_end && last_bit;
  assign load      = !empty_q && (!busy_q || frame_end);
  assign shift     = bit_end && !load;

  mptx_bit_timer #(.TICKS(TICKS)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (busy_q),
    .restart_i (load),
    .tick_i    (tick_i),
    .bit_end_o (bit_end)
  );

  mptx_shifter #(.DATA_W(DATA_W)) i_shifter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .data_i  (hold_q),
    .mpb_i   (hold_mpb_q),
    .shift_i (shift),
    .txd_o   (txd_o),
    .last_o  (last_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q     <= '0;
      hold_mpb_q <= 1'b0;
      empty_q    <= 1'b1;
      idle_q     <= 1'b1;
      busy_q     <= 1'b0;
      hreq_q     <= 1'b0;
      ireq_q     <= 1'b0;
    end else begin
      if (wr_i) begin
        hold_q     <= wdata_i;
        hold_mpb_q <= mpb_i;
      end
      // a write in the transfer cycle refills the register, so it stays full
      empty_q <= wr_i ? 1'b0 : (load ? 1'b1 : empty_q);
      idle_q  <= wr_i ? 1'b0 : ((frame_end && empty_q) ? 1'b1 : idle_q);
      busy_q  <= load ? 1'b1 : (frame_end ? 1'b0 : busy_q);
      hreq_q  <= load;
      ireq_q  <= frame_end && empty_q && !wr_i;
    end
  end

  assign hold_empty_o = empty_q;
  assign line_idle_o  = idle_q;
  assign hold_req_o   = hreq_q;
  assign idle_req_o   = ireq_q;

  a_r5_write_clears_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !hold_empty_o && !line_idle_o);
  a_r2_start_after_transfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_req_o |-> !txd_o);
  a_r6_transfer_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load && !wr_i |=> hold_empty_o && hold_req_o);
  a_r4_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !load |=> $stable(txd_o));
  a_r9_idle_pulse_mark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_req_o |-> line_idle_o && txd_o);
  a_r9_idle_is_mark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_idle_o |-> txd_o);
endmodule

// File: tb/test_mptx_serial_tx.sv
module test_mptx_serial_tx;
  localparam int TPB = 16;
  localparam int FB  = 11;

  logic clk = 1'b0, rst_ni = 1'b0, tick_i = 1'b0, wr_i = 1'b0, mpb_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic txd_o, hold_empty_o, line_idle_o, hold_req_o, idle_req_o;

  mptx_serial_tx i_mptx_serial_tx (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .wr_i(wr_i), .wdata_i(wdata_i),
    .mpb_i(mpb_i), .txd_o(txd_o), .hold_empty_o(hold_empty_o),
    .line_idle_o(line_idle_o), .hold_req_o(hold_req_o), .idle_req_o(idle_req_o)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [8:0] exp_q[$];
  bit in_frame = 0, prev_tick = 0, prev_wr = 0, prev_empty = 1;
  int tcnt = 0, hreq_cnt = 0, ireq_cnt = 0, exp_ireq = 0, frames_rx = 0, frames_wr = 0;
  logic [FB-1:0] rx_lo, rx_hi;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic exp_bit(input int k, input logic [8:0] f);
    if (k == 0) return 1'b0;
    if (k <= 8) return f[k-1];
    if (k == 9) return f[8];
    return 1'b1;
  endfunction

  task automatic monitor();
    logic [8:0] f;
    if (hold_req_o) hreq_cnt++;
    if (idle_req_o) ireq_cnt++;
    if (prev_wr) chk(!hold_empty_o && !line_idle_o, "R5", "flags after write", {hold_empty_o, line_idle_o}, 0);
    if (in_frame && prev_tick) begin
      tcnt++;
      if (tcnt % TPB == 0 && tcnt < FB*TPB) rx_lo[tcnt/TPB] = txd_o;
      if (tcnt % TPB == TPB-1) rx_hi[tcnt/TPB] = txd_o;
      if (tcnt == FB*TPB/2) chk(!line_idle_o, "R9", "idle flag mid-frame", line_idle_o, 0);
      if (tcnt == FB*TPB) begin
        f = (exp_q.size() > 0) ? exp_q.pop_front() : 9'h1FF;
        frames_rx++;
        for (int k = 0; k < FB; k++) begin
          chk(rx_lo[k] == exp_bit(k, f), (k == 9) ? "R3" : "R2", $sformatf("bit %0d start", k), rx_lo[k], exp_bit(k, f));
          chk(rx_hi[k] == exp_bit(k, f), "R4", $sformatf("bit %0d after 15 ticks", k), rx_hi[k], exp_bit(k, f));
        end
        if (!prev_empty)
          chk(!txd_o && hold_req_o, "R8", "chained start", {txd_o, hold_req_o}, 1);
        else if (prev_wr)
          chk(txd_o && !line_idle_o && !idle_req_o, "R9", "late write gap", {txd_o, line_idle_o, idle_req_o}, 4);
        else begin
          exp_ireq++;
          chk(txd_o && line_idle_o && idle_req_o, "R9", "idle after stop", {txd_o, line_idle_o, idle_req_o}, 7);
        end
        in_frame = 0;
      end
    end
    if (!in_frame && !txd_o) begin
      chk(hold_req_o, "R6", "request pulse at transfer", hold_req_o, 1);
      in_frame = 1;
      tcnt = 0;
      rx_lo[0] = txd_o;
    end
  endtask

  task automatic step(input bit tk, input bit w, input logic [7:0] d, input bit m);
    tick_i = tk; wr_i = w; wdata_i = d; mpb_i = m;
    prev_tick = tk; prev_wr = w;
    if (w) begin
      if (!hold_empty_o && exp_q.size() > 0) exp_q[exp_q.size()-1] = {m, d};
      else begin exp_q.push_back({m, d}); frames_wr++; end
    end
    @(negedge clk);
    monitor();
    prev_empty = hold_empty_o;
  endtask

  task automatic drain(input bit dense);
    for (int i = 0; i < 20000; i++) begin
      if (!in_frame && hold_empty_o && exp_q.size() == 0) break;
      step(dense ? 1'b1 : ($urandom % 3 == 0), 1'b0, 8'h00, 1'b0);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog all actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    int sent;
    seed = $urandom(32'h1d5e);
    repeat (3) @(negedge clk);
    chk(txd_o && hold_empty_o && line_idle_o && !hold_req_o && !idle_req_o, "R1", "state in reset",
        {txd_o, hold_empty_o, line_idle_o, hold_req_o, idle_req_o}, 28);
    rst_ni = 1'b1;
    step(1'b1, 1'b0, 8'h00, 1'b0);
    chk(txd_o && hold_empty_o && line_idle_o && !hold_req_o && !idle_req_o, "R1", "state after release",
        {txd_o, hold_empty_o, line_idle_o, hold_req_o, idle_req_o}, 28);

    // idle write: start shows two cycles after strobe
    step(1'b0, 1'b1, 8'hA5, 1'b1);
    chk(txd_o, "R7", "line still mark after strobe", txd_o, 1);
    step(1'b0, 1'b0, 8'h00, 1'b0);
    chk(!txd_o && hold_empty_o, "R7", "start bit and empty", {txd_o, hold_empty_o}, 1);
    drain(1'b1);

    // overwrite of a held byte while a frame runs
    step(1'b0, 1'b1, 8'h3C, 1'b0);
    step(1'b0, 1'b0, 8'h00, 1'b0);
    step(1'b0, 1'b1, 8'h11, 1'b0);
    step(1'b0, 1'b1, 8'h22, 1'b1);
    chk(exp_q.size() == 2 && exp_q[1] == 9'h122, "R10", "held byte replaced", exp_q.size(), 2);
    sent = frames_rx;
    drain(1'b0);
    chk(frames_rx - sent == 2, "R10", "frames after overwrite", frames_rx - sent, 2);

    // sparse random ticks, random write timing
    sent = 0;
    for (int i = 0; i < 60000 && sent < 20; i++) begin
      bit w;
      w = hold_empty_o && ($urandom % 60 == 0);
      if (w) sent++;
      step($urandom % 3 == 0, w, 8'($urandom), 1'($urandom));
    end
    drain(1'b0);

    // every cycle a tick, immediate refills: back-to-back frames
    sent = 0;
    for (int i = 0; i < 30000 && sent < 10; i++) begin
      bit w;
      w = hold_empty_o;
      if (w) sent++;
      step(1'b1, w, 8'($urandom), 1'($urandom));
    end
    drain(1'b1);

    chk(exp_q.size() == 0, "R2", "all frames received", exp_q.size(), 0);
    chk(hreq_cnt == frames_wr, "R6", "transfer pulse count", hreq_cnt, frames_wr);
    chk(ireq_cnt == exp_ireq, "R9", "idle pulse count", ireq_cnt, exp_ireq);
    chk(line_idle_o && txd_o, "R9", "final idle mark", {line_idle_o, txd_o}, 3);
    done = 1;
    summary();
    $finish;
  end
endmodule